// File: doc/BRIEF.md
# Armed Dual-Stage Registration Latch Bank

This block holds a bank of independent registration latches for a two-channel motion feedback interface. Each latch has its own 16-bit configuration word. The word picks a feedback channel and the motion directions in which capture is allowed. It also sets up two trigger stages, each watching one source with its own polarity, and chooses how the two stages combine into a single trigger event. The possible sources are two registration inputs, a home input, and the marker pulse of the selected channel.

A latch is armed by a one-cycle strobe. On its first qualifying trigger it records the position of its channel and the number of cycles since the last feedback sample instant. In the same edge it drops armed and raises found. A packed 32-bit status word shows the armed and found flags of every latch. All asynchronous inputs pass through a two-flop synchronizer before any edge detection.

Top module: `reg_latch_bank`

## Requirements
- R1: After reset every latch is neither armed nor found, all captured positions and times are 0, and the status word is 0.
- R2: An arm strobe sets the latch's armed flag and clears its found flag on the next edge. A clear strobe clears both flags. Clear wins over a simultaneous arm, and arm wins over a simultaneous trigger.
- R3: An armed latch with a qualifying trigger drops armed, sets found, and captures the position of the channel chosen by config bit 0 (0 = `pos_ch0`, 1 = `pos_ch1`), all in one edge. Triggers on an unarmed latch are ignored.
- R4: A time counter is zeroed at every edge where `sample_stb` is high and otherwise counts up by one per edge, saturating at all ones. The captured time is the counter value just before the capture edge.
- R5: Stage 1 takes its source from config bits 4:3 and stage 2 from bits 11:10. The codes are 00 = `reg_in[0]`, 01 = `reg_in[1]`, 10 = `home_in`, and 11 = `marker_in` of the selected channel.
- R6: Stage 1 polarity uses bit 6 (rising / high) and bit 7 (falling / low); stage 2 uses bits 13 and 14 the same way. With both bits set, either edge counts and the level condition is always true. With neither set, the stage has no edge and a false level.
- R7: Config bits 9:8 set how the stages combine. 00 = a stage 1 edge alone; 01 = a stage 1 edge while the stage 2 level holds; 10 = an edge on either stage; 11 = a stage 2 edge while the stage 1 level holds.
- R8: A trigger is discarded, and the latch stays armed, unless the direction of the selected channel is enabled. `dir_fwd` = 1 needs config bit 1, and `dir_fwd` = 0 needs config bit 2.
- R9: An input change set up before edge t is registered at edges t and t+1, and any capture it causes happens at edge t+2.
- R10: In the status word, latch i (counting from 0) reports armed at bit 2i and found at bit 2i+1. All higher bits read 0.
- R11: Captured position and time change only on a capture. Config bits 5, 12 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_in | input | 2 | Registration inputs 0 and 1, asynchronous |
| home_in | input | 1 | Home input, asynchronous |
| marker_in | input | 2 | Marker pulse per feedback channel, asynchronous |
| dir_fwd | input | 2 | Per channel: 1 = moving forward, 0 = reverse |
| pos_ch0 | input | POS_W | Position of feedback channel 0 |
| pos_ch1 | input | POS_W | Position of feedback channel 1 |
| sample_stb | input | 1 | Feedback sample instant, restarts time counter |
| cfg_flat | input | N_LATCH*16 | Configuration words, latch i at bits 16i+15:16i |
| arm | input | N_LATCH | Per-latch arm strobe |
| clr | input | N_LATCH | Per-latch clear strobe |
| status | output | 32 | Armed/found flags |
| cap_pos_flat | output | N_LATCH*POS_W | Captured positions, latch i in slice i |
| cap_time_flat | output | N_LATCH*TIME_W | Captured time offsets, latch i in slice i |

## Verification
The bound checker watches every cycle for each latch. It confirms that the effect of arm and clear strobes appears on the following edge, that armed and found are never both set, that found only rises out of the armed state, and that a captured position moves only when found rises. Some behaviour only the bench scenarios can show: the source and polarity decoding, the four combination modes, the direction discard, the three-edge input latency, and the saturating time offset. The bench checks these against its own cycle model of the configuration encoding under random and directed stimulus.

// File: rtl/reg_latch_pkg.sv
package reg_latch_pkg;
   localparam int CFG_W = 16;
   localparam int SRC_N = 5;   // reg0, reg1, home, marker ch0, marker ch1

   typedef struct packed {
      logic       rsv15;
      logic       st2_fall;
      logic       st2_rise;
      logic       rsv12;
      logic [1:0] st2_src;
      logic [1:0] combine;
      logic       st1_fall;
      logic       st1_rise;
      logic       rsv5;
      logic [1:0] st1_src;
      logic       rev_en;
      logic       fwd_en;
      logic       chan;
   } latch_cfg_t;

   typedef enum logic [1:0] {
      COMB_ST1_EDGE  = 2'b00,
      COMB_ST1_GATED = 2'b01,
      COMB_EITHER    = 2'b10,
      COMB_ST2_GATED = 2'b11
   } comb_mode_t;
endpackage

// File: rtl/reg_latch_sync.sv
module reg_latch_sync #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] meta_q, sync_q, prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= d;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign lvl  = sync_q;
   assign rise = sync_q & ~prev_q;
   assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/reg_latch_time.sv
module reg_latch_time #(
   parameter int TIME_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   output logic [TIME_W-1:0] count
);
   localparam logic [TIME_W-1:0] T_MAX = '1;
   logic [TIME_W-1:0] cnt_nxt;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (count == T_MAX) ? count : count + TIME_W'(1);
      end else begin : g_wrap
         assign cnt_nxt = count + TIME_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          count <= '0;
      else if (sample_stb) count <= '0;
      else                 count <= cnt_nxt;
   end
endmodule

// File: rtl/reg_latch_unit.sv
module reg_latch_unit
   import reg_latch_pkg::*;
#(
   parameter int POS_W  = 32,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  latch_cfg_t        cfg,
   input  logic [SRC_N-1:0]  lvl,
   input  logic [SRC_N-1:0]  rise,
   input  logic [SRC_N-1:0]  fall,
   input  logic [1:0]        dir_fwd,
   input  logic [POS_W-1:0]  pos0,
   input  logic [POS_W-1:0]  pos1,
   input  logic [TIME_W-1:0] tnow,
   input  logic              arm,
   input  logic              clr,
   output logic              armed,
   output logic              found,
   output logic [POS_W-1:0]  cap_pos,
   output logic [TIME_W-1:0] cap_time
);
   logic [3:0] c_lvl, c_rise, c_fall;
   logic       lv1, lv2, e1, e2, l1, l2, trig, dir_ok, capture;

   // marker slot follows the selected channel
   assign c_lvl  = {cfg.chan ? lvl[4]  : lvl[3],  lvl[2:0]};
   assign c_rise = {cfg.chan ? rise[4] : rise[3], rise[2:0]};
   assign c_fall = {cfg.chan ? fall[4] : fall[3], fall[2:0]};

   assign lv1 = c_lvl[cfg.st1_src];
   assign lv2 = c_lvl[cfg.st2_src];
   assign e1  = (cfg.st1_rise & c_rise[cfg.st1_src]) | (cfg.st1_fall & c_fall[cfg.st1_src]);
   assign e2  = (cfg.st2_rise & c_rise[cfg.st2_src]) | (cfg.st2_fall & c_fall[cfg.st2_src]);
   assign l1  = (cfg.st1_rise & lv1) | (cfg.st1_fall & ~lv1);
   assign l2  = (cfg.st2_rise & lv2) | (cfg.st2_fall & ~lv2);

   always_comb begin
      unique case (comb_mode_t'(cfg.combine))
         COMB_ST1_EDGE:  trig = e1;
         COMB_ST1_GATED: trig = e1 & l2;
         COMB_EITHER:    trig = e1 | e2;
         COMB_ST2_GATED: trig = e2 & l1;
         default:        trig = 1'b0;
      endcase
   end

   assign dir_ok  = (cfg.chan ? dir_fwd[1] : dir_fwd[0]) ? cfg.fwd_en : cfg.rev_en;
   assign capture = armed & trig & dir_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         found    <= 1'b0;
         cap_pos  <= '0;
         cap_time <= '0;
      end else if (clr) begin
         armed <= 1'b0;
         found <= 1'b0;
      end else if (arm) begin
         armed <= 1'b1;
         found <= 1'b0;
      end else if (capture) begin
         armed    <= 1'b0;
         found    <= 1'b1;
         cap_pos  <= cfg.chan ? pos1 : pos0;
         cap_time <= tnow;
      end
   end
endmodule

// File: rtl/reg_latch_bank.sv
module reg_latch_bank
   import reg_latch_pkg::*;
#(
   parameter int N_LATCH  = 10,
   parameter int POS_W    = 32,
   parameter int TIME_W   = 16,
   parameter bit TIME_SAT = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  reg_in,
   input  logic                        home_in,
   input  logic [1:0]                  marker_in,
   input  logic [1:0]                  dir_fwd,
   input  logic [POS_W-1:0]            pos_ch0,
   input  logic [POS_W-1:0]            pos_ch1,
   input  logic                        sample_stb,
   input  logic [N_LATCH*CFG_W-1:0]    cfg_flat,
   input  logic [N_LATCH-1:0]          arm,
   input  logic [N_LATCH-1:0]          clr,
   output logic [31:0]                 status,
   output logic [N_LATCH*POS_W-1:0]    cap_pos_flat,
   output logic [N_LATCH*TIME_W-1:0]   cap_time_flat
);
   localparam int STAT_USED = 2 * N_LATCH;

   generate
      if (N_LATCH < 1 || N_LATCH > 16) begin : g_bad_n
         $error("reg_latch_bank: N_LATCH must be 1..16");
      end
      if (POS_W < 1 || TIME_W < 2) begin : g_bad_w
         $error("reg_latch_bank: POS_W >= 1 and TIME_W >= 2 required");
      end
   endgenerate

   logic [SRC_N-1:0]  s_lvl, s_rise, s_fall;
   logic [TIME_W-1:0] tnow;
   logic [N_LATCH-1:0] armed_v, found_v;

   reg_latch_sync #(.W(SRC_N)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({marker_in[1], marker_in[0], home_in, reg_in[1], reg_in[0]}),
      .lvl  (s_lvl),
      .rise (s_rise),
      .fall (s_fall)
   );

   reg_latch_time #(.TIME_W(TIME_W), .SATURATE(TIME_SAT)) u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_stb(sample_stb),
      .count     (tnow)
   );

   generate
      for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
         reg_latch_unit #(.POS_W(POS_W), .TIME_W(TIME_W)) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (latch_cfg_t'(cfg_flat[i*CFG_W +: CFG_W])),
            .lvl     (s_lvl),
            .rise    (s_rise),
            .fall    (s_fall),
            .dir_fwd (dir_fwd),
            .pos0    (pos_ch0),
            .pos1    (pos_ch1),
            .tnow    (tnow),
            .arm     (arm[i]),
            .clr     (clr[i]),
            .armed   (armed_v[i]),
            .found   (found_v[i]),
            .cap_pos (cap_pos_flat[i*POS_W +: POS_W]),
            .cap_time(cap_time_flat[i*TIME_W +: TIME_W])
         );
         assign status[2*i]   = armed_v[i];
         assign status[2*i+1] = found_v[i];
      end
      if (STAT_USED < 32) begin : g_pad
         assign status[31:STAT_USED] = '0;
      end
   endgenerate
endmodule

// File: rtl/reg_latch_bank_chk.sv
module reg_latch_bank_chk #(
   parameter int N_LATCH = 10,
   parameter int POS_W   = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_LATCH-1:0]       arm,
   input logic [N_LATCH-1:0]       clr,
   input logic [31:0]              status,
   input logic [N_LATCH*POS_W-1:0] cap_pos_flat
);
   generate
      for (genvar i = 0; i < N_LATCH; i++) begin : g_chk
         AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(arm[i] && !clr[i]) |-> status[2*i] && !status[2*i+1]); // R2
         AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(clr[i]) |-> !status[2*i] && !status[2*i+1]); // R2
         AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(status[2*i] && status[2*i+1])); // R3
         AST_FOUND_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $rose(status[2*i+1]) |-> $past(status[2*i]) && !status[2*i]); // R3
         AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$rose(status[2*i+1]) |-> $stable(cap_pos_flat[i*POS_W +: POS_W])); // R11
      end
   endgenerate
endmodule

bind reg_latch_bank reg_latch_bank_chk #(.N_LATCH(N_LATCH), .POS_W(POS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arm         (arm),
   .clr         (clr),
   .status      (status),
   .cap_pos_flat(cap_pos_flat)
);

// File: tb/reg_latch_bank_tb.sv
`timescale 1ns/1ps
module reg_latch_bank_tb;
   localparam int N  = 10;
   localparam int PW = 32;
   localparam int TW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      reg_in = '0;
   logic            home_in = 1'b0;
   logic [1:0]      marker_in = '0;
   logic [1:0]      dir_fwd = 2'b11;
   logic [PW-1:0]   pos_ch0 = '0, pos_ch1 = '0;
   logic            sample_stb = 1'b0;
   logic [N*16-1:0] cfg_flat = '0;
   logic [N-1:0]    arm = '0, clr = '0;
   logic [31:0]     status;
   logic [N*PW-1:0] cap_pos_flat;
   logic [N*TW-1:0] cap_time_flat;

   int nchecks = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   reg_latch_bank #(.N_LATCH(N), .POS_W(PW), .TIME_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_in(reg_in), .home_in(home_in),
      .marker_in(marker_in), .dir_fwd(dir_fwd), .pos_ch0(pos_ch0),
      .pos_ch1(pos_ch1), .sample_stb(sample_stb), .cfg_flat(cfg_flat),
      .arm(arm), .clr(clr), .status(status), .cap_pos_flat(cap_pos_flat),
      .cap_time_flat(cap_time_flat)
   );

   // ---------------- reference model of the requirements ----------------
   logic [4:0]    m_s1 = '0, m_s2 = '0, m_pv = '0;
   logic [TW-1:0] m_t = '0;
   logic [N-1:0]  m_armed = '0, m_found = '0;
   logic [PW-1:0] m_pos [N];
   logic [TW-1:0] m_time [N];

   function automatic bit stage_edge(input logic [1:0] sel, input bit ch, input bit re, input bit fe,
                                     input logic [4:0] cur, input logic [4:0] old);
      int k = (sel == 2'd3) ? 3 + int'(ch) : int'(sel);   // R5 source codes
      return (re && cur[k] && !old[k]) || (fe && !cur[k] && old[k]);   // R6
   endfunction

   function automatic bit stage_level(input logic [1:0] sel, input bit ch, input bit re, input bit fe,
                                      input logic [4:0] cur);
      int k = (sel == 2'd3) ? 3 + int'(ch) : int'(sel);
      return (re && cur[k]) || (fe && !cur[k]);
   endfunction

   function automatic bit model_trig(input logic [15:0] c, input logic [4:0] cur, input logic [4:0] old);
      bit e1 = stage_edge(c[4:3], c[0], c[6], c[7], cur, old);
      bit e2 = stage_edge(c[11:10], c[0], c[13], c[14], cur, old);
      bit l1 = stage_level(c[4:3], c[0], c[6], c[7], cur);
      bit l2 = stage_level(c[11:10], c[0], c[13], c[14], cur);
      case (c[9:8])            // R7 combination codes
         2'b00:   return e1;
         2'b01:   return e1 && l2;
         2'b10:   return e1 || e2;
         default: return e2 && l1;
      endcase
   endfunction

   function automatic logic [31:0] model_status();
      logic [31:0] s = '0;
      for (int i = 0; i < N; i++) begin
         s[2*i]   = m_armed[i];
         s[2*i+1] = m_found[i];
      end
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_t <= '0;
         m_armed <= '0; m_found <= '0;
         for (int i = 0; i < N; i++) begin
            m_pos[i] <= '0; m_time[i] <= '0;
         end
      end else begin
         m_s1 <= {marker_in, home_in, reg_in};
         m_s2 <= m_s1;
         m_pv <= m_s2;
         m_t  <= sample_stb ? '0 : ((m_t == '1) ? m_t : m_t + 1'b1);
         for (int i = 0; i < N; i++) begin
            logic [15:0] c;
            bit dok, cap;
            c   = cfg_flat[i*16 +: 16];
            dok = dir_fwd[c[0]] ? c[1] : c[2];                 // R8
            cap = m_armed[i] && dok && model_trig(c, m_s2, m_pv);
            if (clr[i]) begin
               m_armed[i] <= 1'b0; m_found[i] <= 1'b0;
            end else if (arm[i]) begin
               m_armed[i] <= 1'b1; m_found[i] <= 1'b0;
            end else if (cap) begin
               m_armed[i] <= 1'b0; m_found[i] <= 1'b1;
               m_pos[i]   <= c[0] ? pos_ch1 : pos_ch0;
               m_time[i]  <= m_t;
            end
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchecks++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2/R3/R5/R6/R7/R8/R10 status vs model", 64'(status), 64'(model_status()));
      for (int i = 0; i < N; i++) begin
         chk("R3/R11 captured position vs model", 64'(cap_pos_flat[i*PW +: PW]), 64'(m_pos[i]));
         chk("R4 captured time vs model", 64'(cap_time_flat[i*TW +: TW]), 64'(m_time[i]));
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchecks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 status after reset", 64'(status), 64'h0);
      chk("R1 positions after reset", 64'(|cap_pos_flat), 64'h0);
      chk("R1 times after reset", 64'(|cap_time_flat), 64'h0);

      // R3/R4/R9: latch 0, channel 0, forward, stage 1 rising on reg_in[0]
      pos_ch0 = 32'h1234_5678;
      pos_ch1 = 32'hCAFE_0001;
      cfg_flat[0 +: 16] = 16'h0042;
      sample_stb = 1'b1; arm[0] = 1'b1;
      tick();
      sample_stb = 1'b0; arm[0] = 1'b0; reg_in[0] = 1'b1;
      tick(); tick();
      chk("R9 no capture before third edge", 64'(status[1:0]), 64'b01);
      tick();
      chk("R9 capture at third edge", 64'(status[1:0]), 64'b10);
      chk("R3 captured channel 0 position", 64'(cap_pos_flat[0 +: PW]), 64'h1234_5678);
      chk("R4 time offset since sample", 64'(cap_time_flat[0 +: TW]), 64'd2);

      // R8: latch 1, reverse only, stage 1 rising on reg_in[1]
      cfg_flat[16 +: 16] = 16'h004C;
      arm[1] = 1'b1;
      tick();
      arm[1] = 1'b0;
      chk("R10 status layout", 64'(status), 64'h6);
      reg_in[1] = 1'b1;
      repeat (4) tick();
      chk("R8 forward trigger discarded", 64'(status[3:2]), 64'b01);
      reg_in[1] = 1'b0; dir_fwd = 2'b10;
      repeat (4) tick();
      reg_in[1] = 1'b1;
      repeat (4) tick();
      chk("R8 reverse trigger captured", 64'(status[3:2]), 64'b10);
      chk("R3 latch 1 position", 64'(cap_pos_flat[PW +: PW]), 64'h1234_5678);

      // R4: saturation of the time offset, latch 2 on home rising
      dir_fwd = 2'b11;
      cfg_flat[32 +: 16] = 16'h0052;
      arm[2] = 1'b1;
      tick();
      arm[2] = 1'b0;
      repeat (65540) tick();
      home_in = 1'b1;
      repeat (3) tick();
      chk("R4 saturated time", 64'(cap_time_flat[2*TW +: TW]), 64'hFFFF);
      chk("R3 latch 2 found", 64'(status[5:4]), 64'b10);

      // random phase: R2 R5 R6 R7 R8 R11 through model comparison each cycle
      for (int cyc = 0; cyc < 4000; cyc++) begin
         if (cyc % 500 == 0)
            for (int i = 0; i < N; i++) cfg_flat[i*16 +: 16] = 16'($urandom);   // R11 reserved bits random
         reg_in[0] = ($urandom % 6 == 0) ? ~reg_in[0] : reg_in[0];
         reg_in[1] = ($urandom % 6 == 0) ? ~reg_in[1] : reg_in[1];
         home_in   = ($urandom % 8 == 0) ? ~home_in : home_in;
         marker_in = 2'($urandom % 10 == 0) | (2'($urandom % 10 == 0) << 1);
         if ($urandom % 16 == 0) dir_fwd = 2'($urandom);
         pos_ch0 = pos_ch0 + 32'($urandom % 5);
         pos_ch1 = pos_ch1 - 32'($urandom % 5);
         sample_stb = ($urandom % 7 == 0);
         for (int i = 0; i < N; i++) begin
            arm[i] = ($urandom % 20 == 0);
            clr[i] = ($urandom % 60 == 0);
         end
         tick();
      end
      arm = '0; clr = '0; sample_stb = 1'b0;
      tick();
      summary();
   end
endmodule